// File: doc/BRIEF.md
# Hardware-Sequenced I2C Master Engine

A single-master I2C controller that runs a complete bus transaction in hardware after one command is loaded. The command names the transfer type (write, read, write-then-read or read-then-write), a 7-bit slave address, one length for the write phase and one for the read phase (1 to 8 bytes each), a bus speed and up to eight bytes of write data. A single `start_i` pulse launches the transaction. From then on the engine sequences every START, address byte, data byte, acknowledge bit, repeated START and STOP. No further command action is needed until `done_o` pulses.

The engine only pulls SCL and SDA low or releases them, through two output-enable pins. Pull-ups and pads are outside the block. There is one master on the bus, so there is no arbitration. The engine never reads SCL back, so a slave cannot stretch the clock. Read bytes are gathered into an internal buffer and presented in parallel on `rd_data_o`. A NACK from the slave ends the transaction early and raises a sticky error flag.

Top module: `i2c_seq_master`

## Requirements
- R1: After reset, and at any time `busy_o` is low, both `scl_oe_o` and `sda_oe_o` are 0 (lines released). A `start_i` pulse while idle raises `busy_o` in the next cycle.
- R2: `rate_sel_i` picks the SCL rate: 0 gives 100 kHz, 1 gives 400 kHz, 2 gives 800 kHz and 3 gives 1 MHz. Every SCL low phase, and every high phase of a data or acknowledge bit, lasts SYS_CLK_HZ/(2*rate) clock cycles.
- R3: `xfer_i` encodes 0 = write, 1 = read, 2 = write-then-read, 3 = read-then-write. The first byte after each START is {address, R/W}, with R/W = 1 for a read phase.
- R4: A length field value n means n+1 bytes (1 to 8). Write byte i is taken from `wr_data_i[8i+7:8i]` and is shifted out MSB first.
- R5: Read byte i of the read phase appears at `rd_data_o[8i+7:8i]`. Bytes beyond the read length, and every byte of a transaction that performed no read, read as zero.
- R6: The master ACKs every read byte except the last byte of the read phase, which it NACKs.
- R7: In a combined transfer, a repeated START separates the two phases, with no STOP between them, and the address is re-sent carrying the second phase's R/W bit.
- R8: A NACK on an address byte or on a written byte ends the transaction with a STOP, and no further bytes are sent. `nack_o` is set and stays high until the next accepted start.
- R9: `done_o` is a one-cycle pulse after the STOP completes. `busy_o` is low in that same cycle.
- R10: `start_i` and all command inputs are ignored while `busy_o` is high.
- R11: SDA changes while SCL is high only to form a START at the beginning of a transaction, a repeated START, or a STOP at the end. Data and acknowledge bits change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse for the loaded command |
| xfer_i | input | 2 | Transfer type |
| addr_i | input | 7 | Slave address |
| wr_len_i | input | 3 | Write byte count minus one |
| rd_len_i | input | 3 | Read byte count minus one |
| rate_sel_i | input | 2 | SCL rate select |
| wr_data_i | input | 64 | Write bytes, byte i at bits 8i+7:8i |
| rd_data_o | output | 64 | Read bytes, byte i at bits 8i+7:8i |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| nack_o | output | 1 | Sticky NACK error of the last transaction |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Resolved SDA line level |

## Verification
Each of the four transfer types is run against a byte-level slave model, using several mixes of write and read lengths at the extremes of 1 and 8 bytes. This separates the phase ordering, the repeated-START placement and the R/W bit of each phase. The master's acknowledge bits show whether the last-byte NACK falls on the right byte. NACKs are injected on a wrong address, on a middle write byte and on the first byte of a combined write phase, to show that the transaction is cut short at the right point with no read phase behind it. Every rate is measured as SCL low and high run lengths. One run re-pulses start with other command inputs mid-transaction, to show they have no effect on the bus.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    XFER_WR    = 2'd0,
    XFER_RD    = 2'd1,
    XFER_WR_RD = 2'd2,
    XFER_RD_WR = 2'd3
  } xfer_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_RS_LO,
    ST_RS_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_END
  } seq_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int unsigned SYS_CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned HALF_100K = SYS_CLK_HZ / 200_000;
  localparam int unsigned HALF_400K = SYS_CLK_HZ / 800_000;
  localparam int unsigned HALF_800K = SYS_CLK_HZ / 1_600_000;
  localparam int unsigned HALF_1M   = SYS_CLK_HZ / 2_000_000;
  localparam int unsigned CNT_W     = $clog2(HALF_100K + 1);

  logic [CNT_W-1:0] cnt_q, limit;

  always_comb begin
    case (sel_i)
      2'd0:    limit = CNT_W'(HALF_100K - 1);
      2'd1:    limit = CNT_W'(HALF_400K - 1);
      2'd2:    limit = CNT_W'(HALF_800K - 1);
      default: limit = CNT_W'(HALF_1M - 1);
    endcase
  end

  assign tick_o = (cnt_q == limit) && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> cnt_q <= limit); // R2
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DEPTH*8-1:0] load_data_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         byte_i,
  output logic [DEPTH*8-1:0] flat_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic [7:0] mem_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q <= '0;
      else if (load_i)                          mem_q <= load_data_i[g*8 +: 8];
      else if (we_i && idx_i == IDX_W'(g))      mem_q <= byte_i;
    end
    assign flat_o[g*8 +: 8] = mem_q;
  end
endmodule

// File: rtl/i2c_seq_master.sv
module i2c_seq_master
  import i2c_seq_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 100_000_000,
  parameter int unsigned MAX_BYTES  = 8,
  parameter int unsigned LEN_W      = $clog2(MAX_BYTES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [1:0]                xfer_i,
  input  logic [6:0]                addr_i,
  input  logic [LEN_W-1:0]          wr_len_i,
  input  logic [LEN_W-1:0]          rd_len_i,
  input  logic [1:0]                rate_sel_i,
  input  logic [MAX_BYTES*8-1:0]    wr_data_i,
  output logic [MAX_BYTES*8-1:0]    rd_data_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      nack_o,
  output logic                      scl_oe_o,
  output logic                      sda_oe_o,
  input  logic                      sda_i
);
  localparam int unsigned FLAT_W = MAX_BYTES * BYTE_W;

  seq_state_e       state_q;
  xfer_e            xfer_q;
  logic [6:0]       addr_q;
  logic [LEN_W-1:0] wlen_q, rlen_q, byte_idx_q, nxt_idx, last_idx;
  logic [1:0]       rate_q;
  logic             phase_q, is_addr_q, nack_q, done_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q, wr_sel;
  logic             tick, accept, phase_rd, rx_byte, last_byte, tx_level, rx_we;
  logic [FLAT_W-1:0] wr_flat;

  assign accept = (state_q == ST_IDLE) && start_i;

  i2c_rate_gen #(.SYS_CLK_HZ(SYS_CLK_HZ)) i_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q == ST_IDLE),
    .sel_i  (rate_q),
    .tick_o (tick)
  );

  i2c_byte_store #(.DEPTH(MAX_BYTES), .IDX_W(LEN_W)) i_wr_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_data_i(wr_data_i),
    .we_i       (1'b0),
    .idx_i      ('0),
    .byte_i     (8'h00),
    .flat_o     (wr_flat)
  );

  i2c_byte_store #(.DEPTH(MAX_BYTES), .IDX_W(LEN_W)) i_rd_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_data_i('0),
    .we_i       (rx_we),
    .idx_i      (byte_idx_q),
    .byte_i     ({shreg_q[6:0], sda_i}),
    .flat_o     (rd_data_o)
  );

  // direction of the active phase
  always_comb begin
    if (phase_q) phase_rd = (xfer_q == XFER_WR_RD);
    else         phase_rd = (xfer_q == XFER_RD) || (xfer_q == XFER_RD_WR);
  end

  assign rx_byte   = !is_addr_q && phase_rd;
  assign last_idx  = phase_rd ? rlen_q : wlen_q;
  assign last_byte = (byte_idx_q == last_idx);
  assign nxt_idx   = is_addr_q ? '0 : byte_idx_q + 1'b1;
  assign wr_sel    = wr_flat[8*int'(nxt_idx) +: 8];
  assign rx_we     = (state_q == ST_BIT_HI) && tick && rx_byte && (bit_cnt_q == 4'd7);

  always_comb begin
    if (bit_cnt_q < 4'd8) tx_level = rx_byte ? 1'b1 : shreg_q[7];
    else                  tx_level = rx_byte ? last_byte : 1'b1;
  end

  always_comb begin
    scl_oe_o = (state_q == ST_BIT_LO) || (state_q == ST_RS_LO) || (state_q == ST_STOP_LO);
    case (state_q)
      ST_START, ST_STOP_LO, ST_STOP_HI: sda_oe_o = 1'b1;
      ST_BIT_LO, ST_BIT_HI:             sda_oe_o = !tx_level;
      default:                          sda_oe_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      xfer_q     <= XFER_WR;
      addr_q     <= '0;
      wlen_q     <= '0;
      rlen_q     <= '0;
      rate_q     <= '0;
      phase_q    <= 1'b0;
      is_addr_q  <= 1'b0;
      byte_idx_q <= '0;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      nack_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          xfer_q  <= xfer_e'(xfer_i);
          addr_q  <= addr_i;
          wlen_q  <= wr_len_i;
          rlen_q  <= rd_len_i;
          rate_q  <= rate_sel_i;
          phase_q <= 1'b0;
          nack_q  <= 1'b0;
          state_q <= ST_START;
        end
        ST_START: if (tick) begin
          is_addr_q  <= 1'b1;
          byte_idx_q <= '0;
          bit_cnt_q  <= '0;
          shreg_q    <= {addr_q, phase_rd};
          state_q    <= ST_BIT_LO;
        end
        ST_BIT_LO: if (tick) state_q <= ST_BIT_HI;
        ST_BIT_HI: if (tick) begin
          if (bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            state_q   <= ST_BIT_LO;
          end else if (!rx_byte && sda_i) begin
            nack_q  <= 1'b1;
            state_q <= ST_STOP_LO;
          end else if (is_addr_q || !last_byte) begin
            is_addr_q  <= 1'b0;
            byte_idx_q <= nxt_idx;
            bit_cnt_q  <= '0;
            shreg_q    <= wr_sel;
            state_q    <= ST_BIT_LO;
          end else if (xfer_q[1] && !phase_q) begin
            phase_q <= 1'b1;
            state_q <= ST_RS_LO;
          end else begin
            state_q <= ST_STOP_LO;
          end
        end
        ST_RS_LO:    if (tick) state_q <= ST_RS_HI;
        ST_RS_HI:    if (tick) state_q <= ST_START;
        ST_STOP_LO:  if (tick) state_q <= ST_STOP_HI;
        ST_STOP_HI:  if (tick) state_q <= ST_STOP_END;
        ST_STOP_END: if (tick) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign nack_o = nack_q;

  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R1
  AST_ADDR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_START && state_q == ST_BIT_LO) |-> is_addr_q); // R3
  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT_LO || state_q == ST_BIT_HI) |-> bit_cnt_q <= 4'd8); // R4
  AST_RS_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RS_HI) |=> (state_q == ST_RS_HI || state_q == ST_START)); // R7
  AST_NACK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> state_q == ST_STOP_LO); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> ($stable(addr_q) && $stable(xfer_q))); // R10
  AST_SDA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT_HI && $past(state_q) == ST_BIT_HI) |-> $stable(sda_oe_o)); // R11
endmodule

// File: tb/test_i2c_seq_master.sv
`timescale 1ns/1ps
module test_i2c_seq_master;
  localparam int SYS_HZ = 8_000_000;
  localparam int MB     = 8;
  localparam logic [6:0] SLV = 7'h5A;
  localparam int K_START = 1, K_RS = 2, K_STOP = 3, K_ADDR = 4, K_WDATA = 5, K_MACK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [1:0]    xfer_i = '0;
  logic [6:0]    addr_i = '0;
  logic [2:0]    wr_len_i = '0, rd_len_i = '0;
  logic [1:0]    rate_sel_i = '0;
  logic [63:0]   wr_data_i = '0;
  logic [63:0]   rd_data_o;
  logic          busy_o, done_o, nack_o, scl_oe_o, sda_oe_o;
  logic          slv_low = 1'b0;
  logic          scl_line, sda_line;

  assign scl_line = ~scl_oe_o;
  assign sda_line = ~(sda_oe_o | slv_low);

  i2c_seq_master #(.SYS_CLK_HZ(SYS_HZ), .MAX_BYTES(MB)) i_i2c_seq_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .xfer_i(xfer_i), .addr_i(addr_i),
    .wr_len_i(wr_len_i), .rd_len_i(rd_len_i), .rate_sel_i(rate_sel_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o),
    .nack_o(nack_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .sda_i(sda_line)
  );

  int n_cmp = 0, n_bad = 0;
  logic [11:0] exp_q[$];
  logic [7:0] wseed = '0, rseed = '0;
  int nack_at = 99;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      K_RS:    return "R7";
      K_ADDR:  return "R3";
      K_WDATA: return "R4";
      K_MACK:  return "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [7:0] stx(input int i);
    return rseed + 8'(i * 29);
  endfunction

  function automatic logic [7:0] wb(input int i);
    return (wseed + 8'(i * 71)) ^ 8'h5C;
  endfunction

  // monitor side of the scoreboard
  task automatic observe(input int k, input logic [7:0] v);
    logic [11:0] item, e;
    item = {4'(k), v};
    if (exp_q.size() == 0) check(tag_of(k), {52'd0, item}, 64'hFFF);
    else begin
      e = exp_q.pop_front();
      check(tag_of(int'(e[11:8])), {52'd0, item}, {52'd0, e});
    end
  endtask

  // byte-level slave model
  logic s_prev_scl = 1'b1, s_prev_sda = 1'b1, s_in_txn = 1'b0, s_ack = 1'b0, s_mack = 1'b0;
  int s_bitn = 0, s_mode = 0, s_txi = 0, s_wcnt = 0;
  logic [7:0] s_sh = '0, s_txb = '0;

  always @(negedge clk) begin
    logic sc, sd;
    sc = scl_line;
    sd = sda_line;
    if (rst_n) begin
      if (s_prev_scl && sc && s_prev_sda && !sd) begin
        observe(s_in_txn ? K_RS : K_START, 8'h00);
        s_in_txn = 1'b1; s_mode = 1; s_bitn = 0; slv_low = 1'b0;
      end else if (s_prev_scl && sc && !s_prev_sda && sd) begin
        observe(K_STOP, 8'h00);
        s_in_txn = 1'b0; s_mode = 0; slv_low = 1'b0;
      end else if (!s_prev_scl && sc) begin
        if (s_mode != 0) begin
          if (s_bitn < 8) s_sh = {s_sh[6:0], sd};
          else if (s_bitn == 8) s_mack = !sd;
          s_bitn++;
        end
      end else if (s_prev_scl && !sc && s_mode != 0) begin
        if (s_bitn == 8) begin
          if (s_mode == 1) begin
            observe(K_ADDR, s_sh); s_ack = (s_sh[7:1] == SLV); slv_low = s_ack;
          end else if (s_mode == 2) begin
            observe(K_WDATA, s_sh); s_ack = (s_wcnt != nack_at); slv_low = s_ack;
          end else slv_low = 1'b0;
        end else if (s_bitn == 9) begin
          s_bitn = 0; slv_low = 1'b0;
          if (s_mode == 1) begin
            if (!s_ack) s_mode = 0;
            else if (s_sh[0]) begin
              s_mode = 3; s_txi = 0; s_txb = stx(0); slv_low = !s_txb[7];
            end else begin
              s_mode = 2; s_wcnt = 0;
            end
          end else if (s_mode == 2) begin
            if (!s_ack) s_mode = 0;
            s_wcnt++;
          end else begin
            observe(K_MACK, {7'd0, s_mack});
            if (s_mack) begin
              s_txi++; s_txb = stx(s_txi); slv_low = !s_txb[7];
            end else s_mode = 0;
          end
        end else if (s_mode == 3 && s_bitn >= 1 && s_bitn <= 7) begin
          slv_low = !s_txb[7 - s_bitn];
        end
      end
    end
    s_prev_scl = sc;
    s_prev_sda = sd;
  end

  // SCL run-length measurement
  logic m_prev = 1'b1, hi_valid = 1'b0;
  int m_run = 0, lo_min = 1000, lo_max = 0, hi_min = 1000;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line != m_prev) begin
        if (!m_prev) begin
          if (m_run < lo_min) lo_min = m_run;
          if (m_run > lo_max) lo_max = m_run;
        end else if (hi_valid && m_run < hi_min) hi_min = m_run;
        if (scl_line) hi_valid = 1'b1;
        m_run = 1;
      end else m_run++;
      m_prev = scl_line;
    end
  end

  // driver: pushes expected bus items, then launches the command
  task automatic run(input int x, input logic [6:0] a, input int nw, input int nr,
                     input int rate, input int nk, input logic [7:0] ws,
                     input logic [7:0] rs, input bit poke);
    logic [63:0] wflat, exp_rd;
    bit aborted, got_rd, rd;
    int nph, n, cyc, half;
    wseed = ws; rseed = rs; nack_at = nk;
    for (int i = 0; i < MB; i++) wflat[i*8 +: 8] = wb(i);
    half = (rate == 0) ? 40 : (rate == 1) ? 10 : (rate == 2) ? 5 : 4;
    aborted = 1'b0; got_rd = 1'b0;
    nph = (x >= 2) ? 2 : 1;
    exp_q.push_back({4'(K_START), 8'h00});
    for (int p = 0; p < nph && !aborted; p++) begin
      rd = (p == 0) ? (x == 1 || x == 3) : (x == 2);
      if (p == 1) exp_q.push_back({4'(K_RS), 8'h00});
      exp_q.push_back({4'(K_ADDR), a, rd});
      if (a != SLV) aborted = 1'b1;
      else begin
        n = rd ? nr : nw;
        for (int i = 0; i < n && !aborted; i++) begin
          if (rd) exp_q.push_back({4'(K_MACK), 7'd0, (i != n - 1)});
          else begin
            exp_q.push_back({4'(K_WDATA), wb(i)});
            if (i == nk) aborted = 1'b1;
          end
        end
        if (rd) got_rd = 1'b1;
      end
    end
    exp_q.push_back({4'(K_STOP), 8'h00});
    for (int i = 0; i < MB; i++) exp_rd[i*8 +: 8] = (got_rd && i < nr) ? stx(i) : 8'h00;

    @(posedge clk);
    lo_min = 1000; lo_max = 0; hi_min = 1000; hi_valid = 1'b0;
    @(negedge clk);
    xfer_i = 2'(x); addr_i = a; wr_len_i = 3'(nw - 1); rd_len_i = 3'(nr - 1);
    rate_sel_i = 2'(rate); wr_data_i = wflat; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R1 busy after start", {63'd0, busy_o}, 64'd1);
    if (poke) begin
      repeat (40) @(negedge clk);
      addr_i = 7'h22; xfer_i = 2'd0; rate_sel_i = 2'd0; wr_data_i = '1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 done with busy low", {62'd0, done_o, busy_o}, 64'd2);
    check("R8 nack flag", {63'd0, nack_o}, {63'd0, aborted});
    @(negedge clk);
    check("R9 done single pulse", {63'd0, done_o}, 64'd0);
    check("R5 read data", rd_data_o, exp_rd);
    check("R3 all bus items seen", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    check("R2 scl low min", 64'(lo_min), 64'(half));
    check("R2 scl low max", 64'(lo_max), 64'(half));
    check("R2 scl high min", 64'(hi_min), 64'(half));
    if (poke) begin
      repeat (10) @(negedge clk);
      check("R10 no relaunch", {63'd0, busy_o}, 64'd0);
    end
    check("R8 nack held", {63'd0, nack_o}, {63'd0, aborted});
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset lines", {62'd0, scl_oe_o, sda_oe_o}, 64'd0);
    check("R1 reset flags", {61'd0, busy_o, done_o, nack_o}, 64'd0);
    check("R5 reset read data", rd_data_o, 64'd0);
    run(0, SLV, 3, 1, 3, 99, 8'h11, 8'h00, 1'b0); // R4 plain write
    run(1, SLV, 1, 4, 2, 99, 8'h00, 8'h3C, 1'b0); // R6 plain read
    run(2, SLV, 2, 8, 1, 99, 8'hA7, 8'h81, 1'b0); // R7 write then read
    run(3, SLV, 8, 1, 3, 99, 8'h42, 8'hE5, 1'b0); // R7 read then write
    run(0, SLV, 1, 1, 0, 99, 8'h90, 8'h00, 1'b0); // R2 slowest rate
    run(0, 7'h11, 4, 1, 3, 99, 8'h20, 8'h00, 1'b0); // R8 address nack
    run(0, SLV, 5, 1, 2, 2, 8'h63, 8'h00, 1'b0);  // R8 data nack mid phase
    run(2, SLV, 3, 5, 3, 0, 8'h05, 8'h77, 1'b0);  // R8 nack blocks read phase
    run(1, SLV, 1, 8, 3, 99, 8'h00, 8'hC4, 1'b1); // R10 restart ignored
    run(1, SLV, 1, 1, 1, 99, 8'h00, 8'h5E, 1'b0); // R5 stale bytes cleared
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule